// File: doc/BRIEF.md
# Fabric Word Aligner and Inversion-Removing Line Decoder

This block sits behind a deserializer whose own comma search and decoding are switched off. Every clock of the local board clock it receives one 20-bit word that may straddle two line symbols at any of the 20 possible bit offsets. It keeps the previous word, forms a 40-bit view of the stream and tests every offset for the idle symbol. After a programmable run of idle hits at one offset it locks there. From then on it slices one symbol per clock, reads the 4-bit code field to learn whether the 16-bit payload was sent inverted, restores it and classifies the word as data, control, idle or illegal.

The lock state machine has three states. ST_HUNT scans all offsets. On any idle hit it records the lowest hitting offset and moves to ST_CONFIRM. ST_CONFIRM counts consecutive hits at that recorded offset. A miss sends it back to ST_HUNT. The LOCK_HITS-th consecutive hit fixes the offset and moves to ST_LOCK. In ST_LOCK the offset never moves, and LOSS_LIMIT consecutive illegal codes return the machine to ST_HUNT. Because the slice is always taken from the same two-word view and registered once, the delay from symbol to output does not depend on the offset or on the reset.

Top module: `lnk_frame_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_is_ctrl, out_err and locked are all 0 and out_data is 0.
- R2: The input stream is read most significant bit first. A symbol is {code[3:0], payload[15:0]} with the code in bits 19:16, and the idle symbol is code 4'b1001 with payload 16'h00FF. From reset, locked rises on the clock edge that sees the LOCK_HITS-th consecutive window holding the idle symbol at one offset, for every offset 0 to 19, and the offset is frozen while locked.
- R3: While not locked, out_valid and out_err stay 0 whatever arrives.
- R4: Code 4'b1100 is plain data: out_valid=1, out_is_ctrl=0 and out_data equals the payload.
- R5: Code 4'b0011 is inverted data: out_valid=1, out_is_ctrl=0 and out_data is the bitwise complement of the payload.
- R6: Code 4'b0101 (plain) and code 4'b1010 (inverted, payload complemented) are control words: out_valid=1 and out_is_ctrl=1.
- R7: When locked, code 4'b1001 is idle whatever its payload: out_valid=0, out_err=0, out_is_ctrl=0 and out_data=0.
- R8: Any other code is illegal: out_err=1, out_valid=0 and out_data=0.
- R9: LOSS_LIMIT consecutive illegal codes clear locked on the edge that outputs the last of them. A legal word anywhere in a shorter run restarts the count, and locked stays high.
- R10: With the input word n holding the stream delayed by k bits (0 to 19), the outputs after the edge that takes word n reflect symbol n-1, for every k.
- R11: After a loss of lock, the block locks again at a different offset without a reset and decodes at the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local board clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 20 | Unaligned word from the deserializer, earliest bit in bit 19 |
| out_data | output | 16 | Restored payload, 0 when out_valid is low |
| out_valid | output | 1 | Data or control word present |
| out_is_ctrl | output | 1 | Present word is a control word |
| out_err | output | 1 | Present word carried an illegal code |
| locked | output | 1 | Word boundary found and held |

## Verification
The bench builds the block with LOCK_HITS=4 and LOSS_LIMIT=3. With a hit count this small the exact lock edge can be predicted: no lock after four idle symbols, lock after the fifth. The same small count keeps lock sequences short, so one stimulus table can be replayed after a reset at offsets 0, 7 and 19. A loss limit of three lets the table hold a run of two illegal codes that must not drop lock, followed by a directed run of three that must drop it and a relock at offset 11.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    localparam int SYM_W  = 20;
    localparam int PAY_W  = 16;
    localparam int CODE_W = SYM_W - PAY_W;
    localparam int OFF_N  = SYM_W;
    localparam int OFF_W  = $clog2(OFF_N);

    localparam logic [CODE_W-1:0] K_DATA     = 4'b1100;
    localparam logic [CODE_W-1:0] K_DATA_INV = 4'b0011;
    localparam logic [CODE_W-1:0] K_CTRL     = 4'b0101;
    localparam logic [CODE_W-1:0] K_CTRL_INV = 4'b1010;
    localparam logic [CODE_W-1:0] K_IDLE     = 4'b1001;
    localparam logic [PAY_W-1:0]  IDLE_PAY   = 16'h00FF;
    localparam logic [SYM_W-1:0]  IDLE_SYM   = {K_IDLE, IDLE_PAY};

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCK    = 2'd2
    } align_st_e;

    typedef struct packed {
        logic [PAY_W-1:0] data;
        logic             valid;
        logic             is_ctrl;
        logic             err;
    } dec_t;
endpackage

// File: rtl/lnk_window.sv
module lnk_window
    import lnk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] din,
    input  logic [OFF_W-1:0] sel_off,
    output logic [OFF_N-1:0] hit_vec,
    output logic [SYM_W-1:0] sel_word
);
    logic [SYM_W-1:0]   prev_q;
    logic [2*SYM_W-1:0] view;
    logic [SYM_W-1:0]   cand [OFF_N];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    assign view = {prev_q, din};

    for (genvar g = 0; g < OFF_N; g++) begin : g_off
        assign cand[g]    = view[2*SYM_W-1-g -: SYM_W];
        assign hit_vec[g] = (cand[g] == IDLE_SYM);
    end

    assign sel_word = cand[sel_off];
endmodule

// File: rtl/lnk_sym_decode.sv
module lnk_sym_decode
    import lnk_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output dec_t             dec
);
    logic [CODE_W-1:0] code;
    logic [PAY_W-1:0]  pay;

    assign code = sym[SYM_W-1 -: CODE_W];
    assign pay  = sym[PAY_W-1:0];

    always_comb begin
        dec = '0;
        case (code)
            K_DATA:     begin dec.valid = 1'b1; dec.data = pay;  end
            K_DATA_INV: begin dec.valid = 1'b1; dec.data = ~pay; end
            K_CTRL:     begin dec.valid = 1'b1; dec.is_ctrl = 1'b1; dec.data = pay;  end
            K_CTRL_INV: begin dec.valid = 1'b1; dec.is_ctrl = 1'b1; dec.data = ~pay; end
            K_IDLE:     dec = '0;
            default:    dec.err = 1'b1;
        endcase
    end
endmodule

// File: rtl/lnk_align_fsm.sv
module lnk_align_fsm
    import lnk_pkg::*;
#(
    parameter int LOCK_HITS  = 4,
    parameter int LOSS_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_N-1:0] hit_vec,
    input  logic             sym_err,
    output align_st_e        state,
    output logic [OFF_W-1:0] off
);
    localparam int HIT_W = $clog2(LOCK_HITS + 1);
    localparam int BAD_W = $clog2(LOSS_LIMIT + 1);

    align_st_e        st_q, st_d;
    logic [OFF_W-1:0] cand_q, cand_d, off_q, off_d, first_off;
    logic [HIT_W-1:0] hit_q, hit_d;
    logic [BAD_W-1:0] bad_q, bad_d;
    logic             any_hit;

    always_comb begin
        first_off = '0;
        for (int i = OFF_N - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_off = OFF_W'(i);
        end
    end
    assign any_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            cand_q <= '0;
            off_q  <= '0;
            hit_q  <= '0;
            bad_q  <= '0;
        end else begin
            st_q   <= st_d;
            cand_q <= cand_d;
            off_q  <= off_d;
            hit_q  <= hit_d;
            bad_q  <= bad_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cand_d = cand_q;
        off_d  = off_q;
        hit_d  = hit_q;
        bad_d  = bad_q;
        unique case (st_q)
            ST_HUNT: begin
                if (any_hit) begin
                    cand_d = first_off;
                    hit_d  = HIT_W'(1);
                    st_d   = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (hit_vec[cand_q]) begin
                    if (hit_q == HIT_W'(LOCK_HITS - 1)) begin
                        off_d = cand_q;
                        bad_d = '0;
                        st_d  = ST_LOCK;
                    end else begin
                        hit_d = hit_q + HIT_W'(1);
                    end
                end else begin
                    st_d = ST_HUNT;
                end
            end
            ST_LOCK: begin
                if (sym_err) begin
                    if (bad_q == BAD_W'(LOSS_LIMIT - 1)) begin
                        bad_d = '0;
                        st_d  = ST_HUNT;
                    end else begin
                        bad_d = bad_q + BAD_W'(1);
                    end
                end else begin
                    bad_d = '0;
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    assign state = st_q;
    assign off   = off_q;
endmodule

// File: rtl/lnk_frame_rx.sv
module lnk_frame_rx
    import lnk_pkg::*;
#(
    parameter int LOCK_HITS  = 4,
    parameter int LOSS_LIMIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [19:0] rx_word,
    output logic [15:0] out_data,
    output logic        out_valid,
    output logic        out_is_ctrl,
    output logic        out_err,
    output logic        locked
);
    logic [OFF_N-1:0] hit_vec;
    logic [SYM_W-1:0] sel_word;
    logic [OFF_W-1:0] lock_off;
    align_st_e        state;
    dec_t             dec;

    lnk_window u_win (
        .clk(clk), .rst(rst), .din(rx_word), .sel_off(lock_off),
        .hit_vec(hit_vec), .sel_word(sel_word)
    );

    lnk_sym_decode u_dec (.sym(sel_word), .dec(dec));

    lnk_align_fsm #(.LOCK_HITS(LOCK_HITS), .LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
        .clk(clk), .rst(rst), .hit_vec(hit_vec),
        .sym_err(dec.err && (state == ST_LOCK)),
        .state(state), .off(lock_off)
    );

    always_ff @(posedge clk) begin
        if (rst || state != ST_LOCK) begin
            out_data    <= '0;
            out_valid   <= 1'b0;
            out_is_ctrl <= 1'b0;
            out_err     <= 1'b0;
        end else begin
            out_data    <= dec.data;
            out_valid   <= dec.valid;
            out_is_ctrl <= dec.is_ctrl;
            out_err     <= dec.err;
        end
    end

    assign locked = (state == ST_LOCK);
endmodule

// File: rtl/lnk_frame_rx_chk.sv
module lnk_frame_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_is_ctrl,
    input logic       out_err,
    input logic       locked,
    input logic [4:0] lock_off
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && !locked));

    p_quiet_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid || out_err) |-> $past(locked));

    p_offset_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(lock_off));

    p_ctrl_is_valid_r6: assert property (@(posedge clk) disable iff (rst)
        out_is_ctrl |-> out_valid);

    p_err_not_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_err && out_valid));

    p_drop_on_err_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> out_err);
endmodule

bind lnk_frame_rx lnk_frame_rx_chk u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_is_ctrl(out_is_ctrl),
    .out_err(out_err), .locked(locked), .lock_off(lock_off)
);

// File: tb/lnk_frame_rx_test.sv
module lnk_frame_rx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] rx_word = '0;
    logic [15:0] out_data;
    logic        out_valid, out_is_ctrl, out_err, locked;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int skew = 0;
    logic [19:0] prev_sym = '0;

    localparam logic [19:0] IDLE = 20'h900FF;
    localparam logic [19:0] ILL  = 20'h01234;

    // {symbol, valid, is_ctrl, err, data}
    localparam logic [38:0] VEC [14] = '{
        {20'hCA5A5, 3'b100, 16'hA5A5},   // R4
        {20'h30F0F, 3'b100, 16'hF0F0},   // R5
        {20'h500BC, 3'b110, 16'h00BC},   // R6
        {20'hAFF43, 3'b110, 16'h00BC},   // R6
        {20'h900FF, 3'b000, 16'h0000},   // R7
        {20'h01234, 3'b001, 16'h0000},   // R8
        {20'hC0000, 3'b100, 16'h0000},   // R4
        {20'hFFFFF, 3'b001, 16'h0000},   // R8
        {20'h75555, 3'b001, 16'h0000},   // R8, second in a row: R9 keeps lock
        {20'h3FFFF, 3'b100, 16'h0000},   // R5
        {20'h51234, 3'b110, 16'h1234},   // R6
        {20'hCFFFF, 3'b100, 16'hFFFF},   // R4
        {20'h91234, 3'b000, 16'h0000},   // R7 idle with other payload
        {20'hAEDCB, 3'b110, 16'h1234}    // R6
    };

    lnk_frame_rx #(.LOCK_HITS(4), .LOSS_LIMIT(3)) uut (
        .clk(clk), .rst(rst), .rx_word(rx_word), .out_data(out_data),
        .out_valid(out_valid), .out_is_ctrl(out_is_ctrl), .out_err(out_err),
        .locked(locked)
    );

    always #5 clk = ~clk;

    function automatic logic [19:0] mk(input logic [19:0] p, input logic [19:0] c, input int k);
        logic [39:0] cat;
        cat = {p, c};
        return cat[k +: 20];
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [19:0] sym);
        @(negedge clk);
        rx_word  = mk(prev_sym, sym, skew);
        prev_sym = sym;
        @(posedge clk);
        #2;
    endtask

    task automatic check_out(input string req, input logic [18:0] exp);
        logic [18:0] act;
        act = {out_valid, out_is_ctrl, out_err, out_data};
        check(act == exp, req, 40'(act), 40'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_word = '0;
        prev_sym = '0;
        @(posedge clk); @(posedge clk); #2;
        check_out("R1 reset outputs", 19'h0);
        check(locked == 1'b0, "R1 reset locked", 40'(locked), 40'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        check_out("R1 first cycle after reset", 19'h0);
    endtask

    task automatic lock_at(input int k);
        skew = k;
        for (int i = 0; i < 3; i++) begin
            send(20'hCA5A5);
            check_out("R3 no output before lock", 19'h0);
        end
        for (int i = 0; i < 4; i++) begin
            send(IDLE);
            check(locked == 1'b0, "R2 locked too early", 40'(locked), 40'h0);
            check_out("R3 quiet while searching", 19'h0);
        end
        send(IDLE);
        check(locked == 1'b1, "R2 lock on 4th hit", 40'(locked), 40'h1);
    endtask

    task automatic run_table();
        for (int i = 0; i < 14; i++) begin
            send(VEC[i][38:19]);
            if (i > 0) check_out("R10 table (R4-R8 codes)", VEC[i-1][18:0]);
            check(locked == 1'b1, "R9 lock held", 40'(locked), 40'h1);
        end
        send(IDLE);
        check_out("R10 table tail", VEC[13][18:0]);
    endtask

    initial begin
        #(10 * 200000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int skews [3] = '{0, 7, 19};
        foreach (skews[s]) begin
            do_reset();
            lock_at(skews[s]);
            run_table();
        end

        // R9: three illegal codes in a row drop lock
        send(ILL);
        send(ILL);
        check_out("R8 illegal err", 19'h10000);
        check(locked == 1'b1, "R9 one illegal keeps lock", 40'(locked), 40'h1);
        send(ILL);
        check(locked == 1'b1, "R9 two illegal keep lock", 40'(locked), 40'h1);
        send(IDLE);
        check_out("R9 third illegal flagged", 19'h10000);
        check(locked == 1'b0, "R9 loss of lock", 40'(locked), 40'h0);

        // R11: relock at a new offset without reset
        skew = 11;
        for (int i = 0; i < 10; i++) begin
            send(IDLE);
            if (!locked) check_out("R3 quiet during relock", 19'h0);
        end
        check(locked == 1'b1, "R11 relocked", 40'(locked), 40'h1);
        send(20'h3A5A5);
        send(IDLE);
        check_out("R11 decode at new offset", {3'b100, 16'h5A5A});
        send(20'h5C3C3);
        send(IDLE);
        check_out("R11 control at new offset", {3'b110, 16'hC3C3});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule